// File: doc/BRIEF.md
# Double-Buffered Two-Compare PWM Timer

This block is a 16-bit up-counting timer with a pulse-width mode. A prescaler turns the system clock, or a synchronised external clock pin, into a count enable. In pulse-width mode, two compare values set the waveform. When the counter reaches the edge compare, the output latch takes one programmable level. When it reaches the period compare, the latch takes a second programmable level and the counter jumps back to the fixed start value FFFCh.

Software writes the compare values through a small register port. These writes land in shadow registers. The shadow values move into the active compare registers only when a period ends, so a change made in the middle of a period never cuts a pulse short. When pulse-width mode is off, the counter runs freely, wraps past FFFFh, and leaves the output latch untouched.

Top module: `pwmt_top`

## Requirements
- R1: After synchronous reset, `pwm_out` is 0 and `pwm_oe` is 0. The control register, both shadow compares and the output latch are all cleared.
- R2: In pulse-width mode, when a count enable arrives while the counter equals the active edge compare, the output latch takes control bit 0 (edge level).
- R3: In pulse-width mode, when a count enable arrives while the counter equals the active period compare, the output latch takes control bit 1 (period level) and the counter loads FFFCh. One period therefore lasts (period compare + 5) count enables.
- R4: A write to address 0 (edge compare) or address 1 (period compare) changes only a shadow register. The active compare registers take the shadow values only on a period-compare match, so the period that is running keeps its old timing.
- R5: On the first clock edge after control bit 3 (mode enable) goes from 0 to 1, both shadow values load into the active compares and the counter loads FFFCh. This happens whether or not a count enable is present.
- R6: If the counter matches the edge compare and the period compare on the same count enable, the period match wins. The output takes the period level and the counter reloads.
- R7: Control bits 5:4 select the count enable. Code 0 gives one enable every 2 clocks, code 1 every 4, code 2 every 8. Code 3 gives one enable per rising edge of `ext_clk`, detected after a two-flop synchroniser. Two count enables never fall on consecutive clocks.
- R8: With control bit 3 at 0, the output latch holds its value whatever the counter and compare values are.
- R9: `pwm_oe` equals control bit 2 (pin enable). While that bit is 0, `pwm_out` is 0.
- R10: Address 2 writes the control register from `wr_data[5:0]`. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External count clock, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 edge compare, 1 period compare, 2 control |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 1 | Pulse-width output level, 0 while the pin is not enabled |
| pwm_oe | output | 1 | Pin enable for the output |

## Verification
Three events can land on the same clock edge: a period-compare match, which swaps in the shadow values, and an edge-compare match or a shadow write. The bench sets both compares equal, so both matches fall on the same count enable, and it checks that only the period level appears. It also writes new shadow values while a period is running and while the period end is near, and a clock-by-clock reference model shows whether the old values stay in force until the reload.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    localparam int CNT_W = 16;
    localparam int PRE_W = 3;
    localparam logic [CNT_W-1:0] RELOAD_VAL = 16'hFFFC;

    typedef enum logic [1:0] {
        CS_DIV2 = 2'd0,
        CS_DIV4 = 2'd1,
        CS_DIV8 = 2'd2,
        CS_EXT  = 2'd3
    } clk_sel_e;

    typedef struct packed {
        clk_sel_e sel;
        logic     mode_en;
        logic     pin_en;
        logic     lvl_period;
        logic     lvl_edge;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        A_EDGE   = 2'd0,
        A_PERIOD = 2'd1,
        A_CTRL   = 2'd2,
        A_NONE   = 2'd3
    } reg_addr_e;

    function automatic logic [PRE_W-1:0] div_mask(clk_sel_e s);
        case (s)
            CS_DIV2: div_mask = 3'b001;
            CS_DIV4: div_mask = 3'b011;
            default: div_mask = 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler
    import pwmt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e sel,
    input  logic     ext_clk,
    output logic     tick
);
    logic [PRE_W-1:0] pre_q;
    logic [2:0]       sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            sync_q <= '0;
        end else begin
            pre_q  <= pre_q + 1'b1;
            sync_q <= {sync_q[1:0], ext_clk};
        end
    end

    always_comb begin
        if (sel == CS_EXT) tick = sync_q[1] & ~sync_q[2];
        else               tick = ((pre_q & div_mask(sel)) == div_mask(sel));
    end

    p_tick_gap_r7: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/pwmt_core.sv
module pwmt_core
    import pwmt_pkg::*;
#(
    parameter int W = CNT_W,
    parameter logic [W-1:0] RELOAD = RELOAD_VAL
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] sh_edge,
    input  logic [W-1:0] sh_period,
    output logic         level
);
    logic [W-1:0] cnt_q, act_edge_q, act_period_q;
    logic         mode_q, level_q;
    logic         start, hit_edge, hit_period;

    assign start      = ctrl.mode_en & ~mode_q;
    assign hit_period = tick & ctrl.mode_en & (cnt_q == act_period_q);
    assign hit_edge   = tick & ctrl.mode_en & (cnt_q == act_edge_q);
    assign level      = level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q        <= '0;
            act_edge_q   <= '0;
            act_period_q <= '0;
            mode_q       <= 1'b0;
            level_q      <= 1'b0;
        end else begin
            mode_q <= ctrl.mode_en;
            if (start) begin
                cnt_q        <= RELOAD;
                act_edge_q   <= sh_edge;
                act_period_q <= sh_period;
            end else if (hit_period) begin
                cnt_q        <= RELOAD;
                act_edge_q   <= sh_edge;
                act_period_q <= sh_period;
                level_q      <= ctrl.lvl_period;
            end else begin
                if (tick) cnt_q <= cnt_q + 1'b1;
                if (hit_edge) level_q <= ctrl.lvl_edge;
            end
        end
    end

    p_period_level_r3: assert property (@(posedge clk) disable iff (rst)
        (hit_period && !start) |=> (level_q == $past(ctrl.lvl_period)) && (cnt_q == RELOAD));

    p_shadow_held_r4: assert property (@(posedge clk) disable iff (rst)
        (!start && !hit_period) |=> $stable(act_edge_q) && $stable(act_period_q));

    p_start_reload_r5: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt_q == RELOAD) && (act_period_q == $past(sh_period)));

    p_hold_off_r8: assert property (@(posedge clk) disable iff (rst)
        !ctrl.mode_en |=> $stable(level_q));

endmodule

// File: rtl/pwmt_top.sv
module pwmt_top
    import pwmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ext_clk,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wr_data,
    output logic        pwm_out,
    output logic        pwm_oe
);
    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  sh_edge_q, sh_period_q;
    logic              tick, level;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            sh_edge_q   <= '0;
            sh_period_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_EDGE:   sh_edge_q   <= wr_data;
                A_PERIOD: sh_period_q <= wr_data;
                A_CTRL:   ctrl_q      <= ctrl_t'(wr_data[CTRL_W-1:0]);
                default:  ;
            endcase
        end
    end

    pwmt_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .sel     (ctrl_q.sel),
        .ext_clk (ext_clk),
        .tick    (tick)
    );

    pwmt_core #(.W(CNT_W), .RELOAD(RELOAD_VAL)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .ctrl      (ctrl_q),
        .sh_edge   (sh_edge_q),
        .sh_period (sh_period_q),
        .level     (level)
    );

    assign pwm_oe  = ctrl_q.pin_en;
    assign pwm_out = ctrl_q.pin_en & level;

    p_pin_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !pwm_oe |-> !pwm_out);

endmodule

// File: tb/pwmt_top_tb.sv
module pwmt_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_clk = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_out, pwm_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    pwmt_top u_dut (
        .clk(clk), .rst(rst), .ext_clk(ext_clk), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    // Behavioural reference model
    int m_pre, m_s1, m_s2, m_s3, m_cnt, m_ea, m_pa, m_se, m_sp, m_ctrl, m_modeq, m_lvl;

    always @(posedge clk) begin
        int sel, msk, tk, mode, st, n_cnt, n_lvl, n_ea, n_pa;
        if (rst) begin
            m_pre = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_ea = 0; m_pa = 0;
            m_se = 0; m_sp = 0; m_ctrl = 0; m_modeq = 0; m_lvl = 0;
        end else begin
            sel  = (m_ctrl >> 4) & 3;
            msk  = (sel == 0) ? 1 : (sel == 1) ? 3 : 7;
            tk   = (sel == 3) ? (m_s2 && !m_s3) : ((m_pre & msk) == msk);
            mode = (m_ctrl >> 3) & 1;
            st   = mode && !m_modeq;
            n_cnt = m_cnt; n_lvl = m_lvl; n_ea = m_ea; n_pa = m_pa;
            if (st) begin
                n_cnt = 'hFFFC; n_ea = m_se; n_pa = m_sp;
            end else if (tk && mode && m_cnt == m_pa) begin
                n_cnt = 'hFFFC; n_ea = m_se; n_pa = m_sp; n_lvl = (m_ctrl >> 1) & 1;
            end else if (tk) begin
                if (mode && m_cnt == m_ea) n_lvl = m_ctrl & 1;
                n_cnt = (m_cnt + 1) & 'hFFFF;
            end
            m_cnt = n_cnt; m_lvl = n_lvl; m_ea = n_ea; m_pa = n_pa;
            m_modeq = mode;
            m_pre = (m_pre + 1) & 7;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_se = wr_data;
                    2'd1: m_sp = wr_data;
                    2'd2: m_ctrl = wr_data & 'h3F;
                    default: ;
                endcase
            end
        end
    end

    // Clock-by-clock comparison at the falling edge
    always @(negedge clk) begin
        int eoe, eout;
        cycles++;
        if (!rst) begin
            eoe  = (m_ctrl >> 2) & 1;
            eout = eoe ? m_lvl : 0;
            checks++;
            if (pwm_out !== eout[0] || pwm_oe !== eoe[0]) begin
                errors++;
                $display("FAIL %s: out/oe actual %b%b expected %0d%0d at cycle %0d",
                         tag, pwm_out, pwm_oe, eout, eoe, cycles);
            end
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_eq(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    task automatic high_count(input int n, output int hc);
        hc = 0;
        repeat (n) begin
            @(negedge clk);
            #1;
            if (pwm_out) hc++;
        end
    endtask

    // ctrl: [0] edge level, [1] period level, [2] pin enable, [3] mode, [5:4] clock select
    initial begin
        int hc;
        idle(3);
        expect_eq("R1 out", pwm_out, 0);
        expect_eq("R1 oe", pwm_oe, 0);
        rst = 1'b0;
        idle(2);
        expect_eq("R1 out after release", pwm_out, 0);

        tag = "R2";
        wr(2'd0, 16'd3);
        wr(2'd1, 16'd10);
        wr(2'd2, 16'h000D);
        idle(40);
        high_count(60, hc);                 // 2 periods of 15 ticks x2
        expect_eq("R2 R3 high cycles div2", hc, 2 * 7 * 2);

        tag = "R4";
        wr(2'd0, 16'd5);
        wr(2'd1, 16'd20);
        idle(3);
        wr(2'd0, 16'd6);
        idle(80);
        high_count(100, hc);                // 2 periods of 25 ticks x2
        expect_eq("R4 new timing", hc, 2 * 14 * 2);

        tag = "R7";
        wr(2'd2, 16'h001D);                 // div4
        idle(120);
        high_count(200, hc);
        expect_eq("R7 div4 high cycles", hc, 2 * 14 * 4);
        wr(2'd2, 16'h002D);                 // div8
        idle(240);
        high_count(400, hc);
        expect_eq("R7 div8 high cycles", hc, 2 * 14 * 8);

        tag = "R6";
        wr(2'd2, 16'h000D);
        wr(2'd0, 16'd8);
        wr(2'd1, 16'd8);
        idle(120);
        high_count(104, hc);
        expect_eq("R6 period match wins", hc, 0);

        tag = "R5";
        wr(2'd0, 16'd2);
        wr(2'd1, 16'd4);
        wr(2'd2, 16'h0005);                 // mode off
        idle(5);
        wr(2'd2, 16'h000D);                 // mode on: immediate load
        idle(60);
        high_count(72, hc);                 // 4 periods of 9 ticks x2
        expect_eq("R5 restart timing", hc, 4 * 2 * 2);

        tag = "R7";
        wr(2'd2, 16'h003D);                 // external clock
        for (int i = 0; i < 60; i++) begin
            ext_clk = ~ext_clk;
            idle(3);
        end
        ext_clk = 1'b0;

        tag = "R8";
        wr(2'd2, 16'h0005);
        idle(2);
        hc = pwm_out;
        idle(50);
        expect_eq("R8 output held", pwm_out, hc);

        tag = "R10";
        wr(2'd3, 16'hFFFF);
        idle(10);
        expect_eq("R10 addr3 ignored oe", pwm_oe, 1);

        tag = "R9";
        wr(2'd2, 16'h000B);
        idle(40);
        expect_eq("R9 oe low", pwm_oe, 0);
        expect_eq("R9 out gated", pwm_out, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule